// File: doc/BRIEF.md
# Serial Command Front End with Configuration Register Bank

This block is the host-facing serial port of a converter-style device. A host frames bytes with an active-low select line and clocks them in over a serial clock, most significant bit first. The block turns single-byte opcodes for control, calibration and result retrieval into one-cycle strobes in the system clock domain. It also runs multibyte transactions against eighteen 8-bit configuration registers: a two-byte header carries the start address and the register count minus one, followed by the data bytes. Register read data and latched conversion results leave on the serial output.

The select, serial clock and data lines are oversampled by the system clock through synchronizer stages, so every decision is made in one clock domain. A command state machine has five states. `S_CMD` decodes opcodes. `S_RD_HDR` and `S_WR_HDR` wait for the count byte of a read or a write. `S_READ` and `S_WRITE` step through the registers. The transitions are these. `S_CMD` goes to `S_RD_HDR` on a first byte `001a_aaaa` and to `S_WRITE`'s header state `S_WR_HDR` on `010a_aaaa`. Each header state moves to its data state when the count byte arrives. `S_READ` and `S_WRITE` return to `S_CMD` when the byte whose remaining count is zero completes. Every state returns to `S_CMD` the moment select goes high. A conversion result that arrives outside `S_CMD` is discarded, so a register transfer on the output is never corrupted.

Top module: `cmdif_top`

## Requirements
- R1: Opcodes 02h/03h, 04h/05h, 06h/07h, 08h/09h and 0Ah/0Bh each give a one-cycle pulse on cmd_wakeup, cmd_powerdown, cmd_reset, cmd_start and cmd_stop respectively, with bit 0 ignored. Opcode 00h pulses nothing.
- R2: Only the exact bytes 16h, 17h and 19h pulse cmd_sys_offset, cmd_sys_gain and cmd_self_offset. Neighbouring bytes such as 15h, 18h and 1Ah pulse nothing.
- R3: Opcode 12h or 13h pulses cmd_read_data and places the latched conversion word on dout for the following bytes, MSB first.
- R4: A first byte 001a_aaaa (a = start address) followed by 000c_cccc (bits 7:5 ignored) returns c+1 registers from consecutive addresses, one per following byte, each MSB first.
- R5: A first byte 010a_aaaa followed by a count byte 000c_cccc writes the next c+1 bytes to consecutive addresses starting at a.
- R6: Raising cs_n mid-command abandons it. Bytes already completed keep their effect, a partial byte is discarded, and the next frame is decoded as a new command.
- R7: With cs_n held low, the byte after a finished command (including a finished read or write) is decoded as a new command.
- R8: A conv_ready pulse in S_CMD latches conv_word and loads it for shifting out MSB first. A pulse during a register read or write is dropped: neither latched nor loaded.
- R9: After reset, registers 01h, 02h, 04h, 05h, 07h, 09h and 0Fh hold 80h, 01h, 14h, 10h, FFh, 10h and 40h. Every other register holds 00h, except 00h, which holds DEV_ID. dout is 0.
- R10: Writes to address 00h and to 12h..1Fh change no register. Address 00h always reads DEV_ID.
- R11: Reads of addresses 12h..1Fh return 00h, and bytes clocked after the last requested register return 00h.
- R12: din is sampled on each sclk rising edge. dout advances on the falling edge, except the falling edge that ends a byte at which new data was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| din | input | 1 | Serial data from host |
| conv_ready | input | 1 | One-cycle pulse: new conversion word valid |
| conv_word | input | DATA_W | Conversion result |
| dout | output | 1 | Serial data to host |
| cmd_wakeup | output | 1 | Wake-up strobe |
| cmd_powerdown | output | 1 | Power-down strobe |
| cmd_reset | output | 1 | Reset-request strobe |
| cmd_start | output | 1 | Start-conversion strobe |
| cmd_stop | output | 1 | Stop-conversion strobe |
| cmd_sys_offset | output | 1 | System offset calibration strobe |
| cmd_sys_gain | output | 1 | System gain calibration strobe |
| cmd_self_offset | output | 1 | Self offset calibration strobe |
| cmd_read_data | output | 1 | Data-read strobe |
| regs_flat | output | 144 | Register contents, address i at bits 8i+7:8i |

## Verification
Every opcode with both values of its don't-care bit is sent. Near-miss bytes next to the exact calibration codes are sent too, so exact-match decoding is told apart from masked decoding, and the counts show that no-op and unknown bytes pulse nothing. Register reads and writes are run in separate frames and back to back under a held-low select. These runs show whether the byte counter restarts at command boundaries and whether addresses increment. Out-of-range addresses, the read-only identity register and an abort in the middle of a byte test the ignore and discard rules. A conversion pulse injected in the middle of a register read, with the latched word read back afterwards, distinguishes blocking from loading.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

    localparam int REG_COUNT = 18;
    localparam int ADDR_W    = 5;

    typedef enum logic [2:0] {
        S_CMD,
        S_RD_HDR,
        S_WR_HDR,
        S_READ,
        S_WRITE
    } cmd_state_e;

    typedef struct packed {
        logic wakeup;
        logic powerdown;
        logic reset;
        logic start;
        logic stop;
        logic sys_offset;
        logic sys_gain;
        logic self_offset;
        logic read_data;
    } cmd_strobe_t;

    function automatic logic [7:0] reg_reset_value(input int unsigned idx);
        case (idx)
            1:       return 8'h80;
            2:       return 8'h01;
            4:       return 8'h14;
            5:       return 8'h10;
            7:       return 8'hFF;
            9:       return 8'h10;
            15:      return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cmdif_serial.sv
module cmdif_serial #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       din,
    output logic       sel,
    output logic       sclk_fall,
    output logic       byte_done,
    output logic [7:0] byte_val
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] cs_pipe, ck_pipe, di_pipe;
    logic         ck_last;
    logic         ck_rise;
    logic [2:0]   bit_cnt;
    logic [6:0]   acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pipe <= '1;
            ck_pipe <= '0;
            di_pipe <= '0;
            ck_last <= 1'b0;
        end else begin
            cs_pipe <= {cs_pipe[TOP-1:0], cs_n};
            ck_pipe <= {ck_pipe[TOP-1:0], sclk};
            di_pipe <= {di_pipe[TOP-1:0], din};
            ck_last <= ck_pipe[TOP];
        end
    end

    assign sel       = !cs_pipe[TOP];
    assign ck_rise   = sel && ck_pipe[TOP] && !ck_last;
    assign sclk_fall = sel && !ck_pipe[TOP] && ck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            acc       <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (ck_rise) begin
                acc     <= {acc[5:0], di_pipe[TOP]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done <= 1'b1;
                    byte_val  <= {acc, di_pipe[TOP]};
                end
            end
        end
    end

endmodule

// File: rtl/cmdif_txshift.sv
module cmdif_txshift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              shift_pulse,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              load_fresh,
    output logic              dout
);
    logic [DATA_W-1:0] sr;
    logic              fresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            fresh <= 1'b0;
        end else if (load) begin
            sr    <= load_val;
            fresh <= load_fresh;
        end else if (!sel) begin
            fresh <= 1'b0;
        end else if (shift_pulse) begin
            if (fresh) fresh <= 1'b0;
            else       sr    <= {sr[DATA_W-2:0], 1'b0};
        end
    end

    assign dout = sr[DATA_W-1];

endmodule

// File: rtl/cmdif_regbank.sv
module cmdif_regbank
    import cmdif_pkg::*;
#(
    parameter logic [7:0] DEV_ID = 8'h0C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    output logic [REG_COUNT*8-1:0] regs_flat
);
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (i == 0) begin : g_id
            assign regs_flat[7:0] = DEV_ID;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              q <= reg_reset_value(i);
                else if (wr_en && addr == ADDR_W'(i))    q <= wr_data;
            end
            assign regs_flat[i*8 +: 8] = q;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (addr == ADDR_W'(i)) rd_data = regs_flat[i*8 +: 8];
        end
    end

endmodule

// File: rtl/cmdif_fsm.sv
module cmdif_fsm
    import cmdif_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    input  logic              conv_ready,
    input  logic [DATA_W-1:0] conv_word,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output cmd_strobe_t       strobe,
    output logic              load,
    output logic [DATA_W-1:0] load_val,
    output logic              load_fresh,
    output logic              busy,
    output cmd_state_e        state,
    output logic [DATA_W-1:0] result_hold
);
    localparam int PAD_W = DATA_W - 8;

    cmd_state_e        state_nx;
    logic [ADDR_W-1:0] addr_q, cnt_q;
    logic              take;

    assign take     = sel && byte_done;
    assign busy     = (state != S_CMD);
    assign reg_addr = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_CMD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!sel) begin
            state_nx = S_CMD;
        end else if (byte_done) begin
            unique case (state)
                S_CMD: begin
                    if (byte_val[7:5] == 3'b001)      state_nx = S_RD_HDR;
                    else if (byte_val[7:5] == 3'b010) state_nx = S_WR_HDR;
                end
                S_RD_HDR: state_nx = S_READ;
                S_WR_HDR: state_nx = S_WRITE;
                S_READ:   if (cnt_q == '0) state_nx = S_CMD;
                S_WRITE:  if (cnt_q == '0) state_nx = S_CMD;
                default:  state_nx = S_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            cnt_q       <= '0;
            result_hold <= '0;
        end else begin
            if (conv_ready && !busy) result_hold <= conv_word;
            if (take) begin
                unique case (state)
                    S_CMD:    addr_q <= byte_val[ADDR_W-1:0];
                    S_RD_HDR: begin
                        cnt_q  <= byte_val[ADDR_W-1:0];
                        addr_q <= addr_q + 1'b1;
                    end
                    S_WR_HDR: cnt_q <= byte_val[ADDR_W-1:0];
                    S_READ, S_WRITE: begin
                        addr_q <= addr_q + 1'b1;
                        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        strobe     = '0;
        wr_en      = 1'b0;
        wr_data    = byte_val;
        load       = 1'b0;
        load_val   = conv_word;
        load_fresh = 1'b0;
        if (take) begin
            unique case (state)
                S_CMD: begin
                    unique casez (byte_val)
                        8'b0000_001?: strobe.wakeup      = 1'b1;
                        8'b0000_010?: strobe.powerdown   = 1'b1;
                        8'b0000_011?: strobe.reset       = 1'b1;
                        8'b0000_100?: strobe.start       = 1'b1;
                        8'b0000_101?: strobe.stop        = 1'b1;
                        8'h16:        strobe.sys_offset  = 1'b1;
                        8'h17:        strobe.sys_gain    = 1'b1;
                        8'h19:        strobe.self_offset = 1'b1;
                        8'b0001_001?: begin
                            strobe.read_data = 1'b1;
                            load             = 1'b1;
                            load_val         = result_hold;
                            load_fresh       = 1'b1;
                        end
                        default: ;
                    endcase
                end
                S_RD_HDR: begin
                    load       = 1'b1;
                    load_val   = {rd_data, {PAD_W{1'b0}}};
                    load_fresh = 1'b1;
                end
                S_READ: begin
                    load       = 1'b1;
                    load_val   = (cnt_q == '0) ? '0 : {rd_data, {PAD_W{1'b0}}};
                    load_fresh = 1'b1;
                end
                S_WRITE: wr_en = 1'b1;
                default: ;
            endcase
        end
        if (!load && conv_ready && !busy) begin
            load       = 1'b1;
            load_val   = conv_word;
            load_fresh = 1'b0;
        end
    end

endmodule

// File: rtl/cmdif_top.sv
module cmdif_top #(
    parameter int         DATA_W      = 16,
    parameter logic [7:0] DEV_ID      = 8'h0C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cs_n,
    input  logic                              sclk,
    input  logic                              din,
    input  logic                              conv_ready,
    input  logic [DATA_W-1:0]                 conv_word,
    output logic                              dout,
    output logic                              cmd_wakeup,
    output logic                              cmd_powerdown,
    output logic                              cmd_reset,
    output logic                              cmd_start,
    output logic                              cmd_stop,
    output logic                              cmd_sys_offset,
    output logic                              cmd_sys_gain,
    output logic                              cmd_self_offset,
    output logic                              cmd_read_data,
    output logic [cmdif_pkg::REG_COUNT*8-1:0] regs_flat
);
    import cmdif_pkg::*;

    logic              sel, sclk_fall, byte_done;
    logic [7:0]        byte_val, rd_data, wr_data;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en, load, load_fresh, busy;
    logic [DATA_W-1:0] load_val, result_hold;
    cmd_strobe_t       strobe;
    cmd_state_e        state;

    cmdif_serial #(.SYNC_STAGES(SYNC_STAGES)) u_serial (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sel(sel), .sclk_fall(sclk_fall), .byte_done(byte_done), .byte_val(byte_val)
    );

    cmdif_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel), .byte_done(byte_done), .byte_val(byte_val),
        .conv_ready(conv_ready), .conv_word(conv_word), .rd_data(rd_data),
        .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .strobe(strobe),
        .load(load), .load_val(load_val), .load_fresh(load_fresh), .busy(busy),
        .state(state), .result_hold(result_hold)
    );

    cmdif_regbank #(.DEV_ID(DEV_ID)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .regs_flat(regs_flat)
    );

    cmdif_txshift #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .sel(sel), .shift_pulse(sclk_fall), .load(load),
        .load_val(load_val), .load_fresh(load_fresh), .dout(dout)
    );

    assign cmd_wakeup      = strobe.wakeup;
    assign cmd_powerdown   = strobe.powerdown;
    assign cmd_reset       = strobe.reset;
    assign cmd_start       = strobe.start;
    assign cmd_stop        = strobe.stop;
    assign cmd_sys_offset  = strobe.sys_offset;
    assign cmd_sys_gain    = strobe.sys_gain;
    assign cmd_self_offset = strobe.self_offset;
    assign cmd_read_data   = strobe.read_data;

endmodule

// File: rtl/cmdif_chk.sv
module cmdif_chk
    import cmdif_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel,
    input cmd_strobe_t            strobe,
    input logic                   busy,
    input logic                   conv_ready,
    input logic [DATA_W-1:0]      result_hold,
    input cmd_state_e             state,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [REG_COUNT*8-1:0] regs_flat
);
    // R1 R2 R3: at most one command strobe at a time
    p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    // R1: strobes last a single cycle
    p_strobe_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe) |=> !(|strobe));

    // R8: a result arriving during a register transaction is not latched
    p_conv_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_ready && busy) |=> $stable(result_hold));

    // R6: deselect returns the sequencer to opcode decode
    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (state == S_CMD));

    // R10: writes to the identity or unimplemented addresses change nothing
    p_ignored_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_addr == '0 || reg_addr >= ADDR_W'(REG_COUNT))) |=> $stable(regs_flat));

endmodule

bind cmdif_top cmdif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .strobe(strobe), .busy(busy),
    .conv_ready(conv_ready), .result_hold(result_hold), .state(state),
    .wr_en(wr_en), .reg_addr(reg_addr), .regs_flat(regs_flat)
);

// File: tb/cmdif_top_tb_top.sv
module cmdif_top_tb_top;
    localparam int         DATA_W = 16;
    localparam logic [7:0] DEV_ID = 8'h0C;
    localparam int         HALF   = 8;
    localparam int         NREG   = 18;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0, conv_ready = 1'b0;
    logic [DATA_W-1:0] conv_word = '0;
    logic dout, cmd_wakeup, cmd_powerdown, cmd_reset, cmd_start, cmd_stop;
    logic cmd_sys_offset, cmd_sys_gain, cmd_self_offset, cmd_read_data;
    logic [NREG*8-1:0] regs_flat;

    cmdif_top #(.DATA_W(DATA_W), .DEV_ID(DEV_ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .conv_ready(conv_ready), .conv_word(conv_word), .dout(dout),
        .cmd_wakeup(cmd_wakeup), .cmd_powerdown(cmd_powerdown), .cmd_reset(cmd_reset),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_sys_offset(cmd_sys_offset),
        .cmd_sys_gain(cmd_sys_gain), .cmd_self_offset(cmd_self_offset),
        .cmd_read_data(cmd_read_data), .regs_flat(regs_flat)
    );

    always #5 clk = ~clk;

    int vectors = 0, miscompares = 0;
    int n_wake = 0, n_pd = 0, n_rst = 0, n_start = 0, n_stop = 0;
    int n_so = 0, n_sg = 0, n_fo = 0, n_rd = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always @(posedge clk) begin
        if (rst_n) begin
            if (cmd_wakeup)      n_wake++;
            if (cmd_powerdown)   n_pd++;
            if (cmd_reset)       n_rst++;
            if (cmd_start)       n_start++;
            if (cmd_stop)        n_stop++;
            if (cmd_sys_offset)  n_so++;
            if (cmd_sys_gain)    n_sg++;
            if (cmd_self_offset) n_fo++;
            if (cmd_read_data)   n_rd++;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // monitor: pops expected bytes and compares with captured output bytes
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g;
                logic [7:0] e;
                string      t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {24'h0, g}, {24'h0, e});
            end
        end
    end

    function automatic logic [7:0] spec_reset(input int a);
        case (a)
            0:       return DEV_ID;
            1:       return 8'h80;
            2:       return 8'h01;
            4:       return 8'h14;
            5:       return 8'h10;
            7:       return 8'hFF;
            9:       return 8'h10;
            15:      return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_at(input int a);
        return regs_flat[a*8 +: 8];
    endfunction

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b >= 8 - nbits; b--) begin
            din = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = dout;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] rx;
        shift_bits(tx, 8, rx);
    endtask

    // driver: pushes the expected output byte, then the captured one
    task automatic send_exp(input logic [7:0] tx, input logic [7:0] exp, input string tag);
        logic [7:0] rx;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        shift_bits(tx, 8, rx);
        got_q.push_back(rx);
    endtask

    task automatic pulse_conv(input logic [DATA_W-1:0] w);
        @(negedge clk);
        conv_word  = w;
        conv_ready = 1'b1;
        @(negedge clk);
        conv_ready = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] ops [19];
        ops = '{8'h00, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A,
                8'h0B, 8'h16, 8'h17, 8'h19, 8'h12, 8'h13, 8'h15, 8'h18, 8'h1A};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 reset state
        check("R9 dout after reset", {31'h0, dout}, 32'h0);
        for (int a = 0; a < NREG; a++)
            check($sformatf("R9 reset reg %0d", a), {24'h0, reg_at(a)}, {24'h0, spec_reset(a)});

        // R1 R2 R3 opcode decode: first ten in separate frames, rest with select held low
        for (int i = 0; i < 10; i++) begin
            frame_begin(); send(ops[i]); frame_end();
        end
        frame_begin();
        for (int i = 10; i < 19; i++) send(ops[i]);
        frame_end();
        check("R1 wakeup count",     n_wake,  2);
        check("R1 powerdown count",  n_pd,    2);
        check("R1 reset count",      n_rst,   2);
        check("R1 start count",      n_start, 2);
        check("R1 stop count",       n_stop,  2);
        check("R2 sys offset count", n_so,    1);
        check("R2 sys gain count",   n_sg,    1);
        check("R2 self offset count", n_fo,   1);
        check("R3 read data count",  n_rd,    2);

        // R8 R12 idle conversion load, shifted MSB first
        pulse_conv(16'hBEEF);
        repeat (4) @(negedge clk);
        frame_begin();
        send_exp(8'h00, 8'hBE, "R8 R12 idle result high byte");
        send_exp(8'h00, 8'hEF, "R8 R12 idle result low byte");
        frame_end();

        // R5 write three registers from 03h
        frame_begin();
        send(8'h43); send(8'h02); send(8'hA1); send(8'hA2); send(8'hA3);
        frame_end();
        check("R5 reg 3", {24'h0, reg_at(3)}, 32'hA1);
        check("R5 reg 4", {24'h0, reg_at(4)}, 32'hA2);
        check("R5 reg 5", {24'h0, reg_at(5)}, 32'hA3);
        check("R5 reg 6 untouched", {24'h0, reg_at(6)}, 32'h00);

        // R4 R11 R7 read three from 02h, then a no-op and a start under held select
        frame_begin();
        send(8'h22); send(8'h02);
        send_exp(8'h00, 8'h01, "R4 read reg 2");
        send_exp(8'h00, 8'hA1, "R4 read reg 3");
        send_exp(8'h00, 8'hA2, "R4 read reg 4");
        send_exp(8'h00, 8'h00, "R11 byte after last register");
        send_exp(8'h08, 8'h00, "R11 second byte after read");
        frame_end();
        check("R7 start after read with select low", n_start, 3);

        // R10 writes beyond 11h and to the identity register
        frame_begin();
        send(8'h51); send(8'h01); send(8'h5C); send(8'h77);
        frame_end();
        frame_begin();
        send(8'h40); send(8'h00); send(8'hFF);
        frame_end();
        check("R10 reg 11h written", {24'h0, reg_at(17)}, 32'h5C);
        check("R10 identity unchanged", {24'h0, reg_at(0)}, {24'h0, DEV_ID});
        frame_begin();
        send(8'h31); send(8'h02);
        send_exp(8'h00, 8'h5C, "R4 read reg 11h");
        send_exp(8'h00, 8'h00, "R11 read 12h");
        send_exp(8'h00, 8'h00, "R11 read 13h");
        frame_end();
        frame_begin();
        send(8'h20); send(8'h00);
        send_exp(8'h00, DEV_ID, "R10 identity read");
        frame_end();

        // R6 abort in the middle of the second data byte
        begin
            logic [7:0] rx;
            frame_begin();
            send(8'h46); send(8'h01); send(8'h5A);
            shift_bits(8'h3C, 4, rx);
            frame_end();
        end
        check("R6 completed byte kept", {24'h0, reg_at(6)}, 32'h5A);
        check("R6 partial byte discarded", {24'h0, reg_at(7)}, 32'hFF);
        frame_begin(); send(8'h08); frame_end();
        check("R6 R7 fresh command after abort", n_start, 4);
        frame_begin();
        send(8'h27); send(8'h00);
        send_exp(8'h00, 8'hFF, "R6 read reg 7");
        frame_end();

        // R8 conversion pulse during a register read is dropped
        frame_begin();
        send(8'h23); send(8'h01);
        fork
            send_exp(8'h00, 8'hA1, "R8 read undisturbed reg 3");
            begin
                repeat (40) @(negedge clk);
                conv_word  = 16'h1234;
                conv_ready = 1'b1;
                @(negedge clk);
                conv_ready = 1'b0;
            end
        join
        send_exp(8'h00, 8'hA2, "R8 read undisturbed reg 4");
        frame_end();
        frame_begin();
        send(8'h12);
        send_exp(8'h00, 8'hBE, "R3 R8 latched word high after blocked pulse");
        send_exp(8'h00, 8'hEF, "R3 R8 latched word low after blocked pulse");
        frame_end();
        pulse_conv(16'h1234);
        repeat (4) @(negedge clk);
        frame_begin();
        send_exp(8'h00, 8'h12, "R8 new idle result high");
        send_exp(8'h00, 8'h34, "R8 new idle result low");
        frame_end();

        repeat (5) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule